// File: doc/BRIEF.md
# Round-Robin Slave-Port Arbiter with Idle Parking and Slot Limit

This block decides which of several bus masters owns one slave port of an interconnect. Each master raises a request and, while it is in the middle of a burst, a burst flag. The arbiter registers its decision: the requests and burst flags seen in one cycle set the one-hot grant, a valid flag and a binary owner index from the next clock edge onward. The index drives the data-path multiplexer, which is outside this block.

An owner keeps the port for as long as it requests, unless a programmable slot limit is reached. When the owner drops its request, the other requesters compete in round-robin order. When nobody requests, the grant is parked according to one of three policies: no owner, the last owner, or a fixed master. A parked master that then requests already holds the grant and loses no cycle. The policy, the fixed index and the slot limit are static settings. The arbiter takes them in only on cycles when no owner is actively requesting.

Top module: `bus_slot_arbiter`

## Requirements
- R1: `gnt_o` is always one-hot or zero. `gnt_vld_o` is high exactly when one bit is set, and then `gnt_o[gnt_idx_o]` is that bit. Reset clears the grant.
- R2: A decision is registered. The requests of one cycle set the grant after the next clock edge. An owner that keeps requesting keeps the grant unless R8 applies.
- R3: When the owner does not request, the requesters are searched in rising index order with wrap-around. The search starts at the master after the most recent arbitration winner. After reset it starts at master 0.
- R4: Park policy code 0 (and the unused code 3): with no requests, no master is granted.
- R5: Park policy code 1: with no requests, the grant rests on the most recent owner. Before the first owner, nothing is granted.
- R6: Park policy code 2: with no requests, the grant rests on `park_idx_i`. An index of N_MST or above parks nothing.
- R7: A parked master that starts to request keeps the grant without any cycle of gap.
- R8: The slot counter is cleared when ownership is taken. It counts each cycle the owner keeps the port and stops at the limit L > 0. When the count equals L, the owner's burst flag is low and another master requests, the grant moves to the next of the other requesters in round-robin order.
- R9: The grant never leaves an owner that is requesting with its burst flag high.
- R10: A slot limit of 0 turns off burst breaking.
- R11: The policy, fixed index and limit are sampled only at clock edges closing a cycle in which no owner requests. A change made while an owner requests has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Request per master |
| burst_i | input | N_MST | High while a master is inside a burst |
| park_mode_i | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed, 3 none |
| park_idx_i | input | IDX_W | Master used by the fixed policy |
| slot_lim_i | input | SLOT_W | Slot cycle limit, 0 disables |
| gnt_o | output | N_MST | One-hot grant |
| gnt_vld_o | output | 1 | A master is granted |
| gnt_idx_o | output | IDX_W | Index of the granted master |

## Verification
The slot-limit break and the end of the owner's burst can land in the same cycle as a competing request. The bench drives an owner past its limit with its burst flag high, so the grant must stay. It then drops the flag in the next cycle and expects the handover at that edge, to the competitor picked by round robin. A second collision comes from a parked master that raises its request in the cycle that would otherwise park. The grant must show no gap. A configuration change made in mid-ownership is checked to take no effect before the next break.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      PARK_NONE  = 2'd0,
      PARK_LAST  = 2'd1,
      PARK_FIXED = 2'd2,
      PARK_RSVD  = 2'd3
   } park_mode_e;
endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin search: first set bit of cand at or after ptr, wrapping.
module arb_rr_pick #(
   parameter int N_MST = 6,
   parameter int IDX_W = 3
) (
   input  logic [N_MST-1:0] cand,
   input  logic [IDX_W-1:0] ptr,
   output logic             hit,
   output logic [IDX_W-1:0] win
);
   generate
      if (N_MST == 1) begin : g_single
         assign hit = cand[0];
         assign win = '0;
      end else begin : g_multi
         always_comb begin
            hit = 1'b0;
            win = '0;
            // scan from farthest offset down so the nearest hit is the last one written
            for (int k = N_MST - 1; k >= 0; k--) begin
               if (cand[(int'(ptr) + k) % N_MST]) begin
                  hit = 1'b1;
                  win = IDX_W'((int'(ptr) + k) % N_MST);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/arb_slot_ctr.sv
// Ownership cycle counter, saturating at the limit.
module arb_slot_ctr #(
   parameter int SLOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [SLOT_W-1:0] limit,
   output logic              at_limit
);
   logic [SLOT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (adv && cnt_q != limit) cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (limit != '0) && (cnt_q == limit);
endmodule

// File: rtl/arb_park_sel.sv
// Chooses where the grant rests while no master requests.
module arb_park_sel
   import arb_pkg::*;
#(
   parameter int N_MST = 6,
   parameter int IDX_W = 3
) (
   input  park_mode_e       mode,
   input  logic             last_vld,
   input  logic [IDX_W-1:0] last_idx,
   input  logic [IDX_W-1:0] fix_idx,
   output logic             park_vld,
   output logic [IDX_W-1:0] park_idx
);
   always_comb begin
      park_vld = 1'b0;
      park_idx = '0;
      unique case (mode)
         PARK_LAST: begin
            park_vld = last_vld;
            park_idx = last_idx;
         end
         PARK_FIXED: begin
            park_vld = int'(fix_idx) < N_MST;
            park_idx = fix_idx;
         end
         default: begin
            park_vld = 1'b0;
            park_idx = '0;
         end
      endcase
   end
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
   import arb_pkg::*;
#(
   parameter int N_MST  = 6,
   parameter int SLOT_W = 8,
   parameter int IDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_MST-1:0]  req_i,
   input  logic [N_MST-1:0]  burst_i,
   input  logic [1:0]        park_mode_i,
   input  logic [IDX_W-1:0]  park_idx_i,
   input  logic [SLOT_W-1:0] slot_lim_i,
   output logic [N_MST-1:0]  gnt_o,
   output logic              gnt_vld_o,
   output logic [IDX_W-1:0]  gnt_idx_o
);
   localparam int LAST_M = N_MST - 1;

   // ownership state
   logic             vld_q, vld_d;
   logic [IDX_W-1:0] own_q, own_d;
   logic [IDX_W-1:0] ptr_q;
   logic             last_vld_q;
   logic [IDX_W-1:0] last_q;

   // configuration captured on idle cycles
   park_mode_e        mode_q;
   logic [IDX_W-1:0]  fix_q;
   logic [SLOT_W-1:0] lim_q;

   logic own_req, own_burst, keep, brk, win_evt;
   logic at_limit, pick_hit, park_vld;
   logic [IDX_W-1:0] pick_win, park_idx;
   logic [N_MST-1:0] others, cand;

   assign own_req   = vld_q && req_i[own_q];
   assign own_burst = burst_i[own_q];
   assign others    = req_i & ~gnt_o;
   assign brk       = own_req && at_limit && !own_burst && (|others);
   assign keep      = own_req && !brk;
   assign cand      = brk ? others : req_i;

   arb_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
      .cand (cand),
      .ptr  (ptr_q),
      .hit  (pick_hit),
      .win  (pick_win)
   );

   arb_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!keep),
      .adv      (keep),
      .limit    (lim_q),
      .at_limit (at_limit)
   );

   arb_park_sel #(.N_MST(N_MST), .IDX_W(IDX_W)) u_park (
      .mode     (mode_q),
      .last_vld (last_vld_q),
      .last_idx (last_q),
      .fix_idx  (fix_q),
      .park_vld (park_vld),
      .park_idx (park_idx)
   );

   always_comb begin
      win_evt = 1'b0;
      vld_d   = 1'b0;
      own_d   = own_q;
      if (keep) begin
         vld_d = 1'b1;
      end else if (pick_hit) begin
         vld_d   = 1'b1;
         own_d   = pick_win;
         win_evt = 1'b1;
      end else if (park_vld) begin
         vld_d = 1'b1;
         own_d = park_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q      <= 1'b0;
         own_q      <= '0;
         ptr_q      <= '0;
         last_vld_q <= 1'b0;
         last_q     <= '0;
      end else begin
         vld_q <= vld_d;
         own_q <= own_d;
         if (win_evt) begin
            ptr_q      <= (int'(pick_win) == LAST_M) ? '0 : pick_win + 1'b1;
            last_vld_q <= 1'b1;
            last_q     <= pick_win;
         end else if (own_req) begin
            last_vld_q <= 1'b1;
            last_q     <= own_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PARK_NONE;
         fix_q  <= '0;
         lim_q  <= '0;
      end else if (!own_req) begin
         mode_q <= park_mode_e'(park_mode_i);
         fix_q  <= park_idx_i;
         lim_q  <= slot_lim_i;
      end
   end

   generate
      for (genvar i = 0; i < N_MST; i++) begin : g_dec
         assign gnt_o[i] = vld_q && (own_q == IDX_W'(i));
      end
   endgenerate

   assign gnt_vld_o = vld_q;
   assign gnt_idx_o = own_q;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
   parameter int N_MST  = 6,
   parameter int IDX_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_MST-1:0] req_i,
   input logic [N_MST-1:0] burst_i,
   input logic [N_MST-1:0] gnt_o,
   input logic             gnt_vld_o,
   input logic [IDX_W-1:0] gnt_idx_o
);
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   a_r1_idx_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o |-> (gnt_o[gnt_idx_o] && $countones(gnt_o) == 1));

   a_r9_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld_o && req_i[gnt_idx_o] && burst_i[gnt_idx_o])
         |=> (gnt_vld_o && gnt_idx_o == $past(gnt_idx_o)));

   // R3: a new owner taken while anyone requested must have been requesting
   a_r3_new_owner_req: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld_o && $past(gnt_vld_o) && gnt_idx_o != $past(gnt_idx_o) && $past(|req_i))
         |-> ((($past(req_i)) >> gnt_idx_o) & 1) != 0);
endmodule

bind bus_slot_arbiter arb_chk #(.N_MST(N_MST), .IDX_W(IDX_W)) u_arb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .burst_i   (burst_i),
   .gnt_o     (gnt_o),
   .gnt_vld_o (gnt_vld_o),
   .gnt_idx_o (gnt_idx_o)
);

// File: tb/tb_bus_slot_arbiter.sv
module tb_bus_slot_arbiter;
   localparam int CLK_P = 10;
   localparam int N     = 6;
   localparam int IW    = 3;
   localparam int SW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_i = '0;
   logic [N-1:0]  burst_i = '0;
   logic [1:0]    park_mode_i = 2'd0;
   logic [IW-1:0] park_idx_i = '0;
   logic [SW-1:0] slot_lim_i = '0;
   logic [N-1:0]  gnt_o;
   logic          gnt_vld_o;
   logic [IW-1:0] gnt_idx_o;

   bus_slot_arbiter #(.N_MST(N), .SLOT_W(SW)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .burst_i(burst_i),
      .park_mode_i(park_mode_i), .park_idx_i(park_idx_i), .slot_lim_i(slot_lim_i),
      .gnt_o(gnt_o), .gnt_vld_o(gnt_vld_o), .gnt_idx_o(gnt_idx_o)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      int    exp;   // -1 = nothing granted
      string tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // shadow configuration, applied together with the next step
   logic [1:0]    s_mode = 2'd0;
   logic [IW-1:0] s_idx  = '0;
   logic [SW-1:0] s_lim  = '0;

   function automatic void judge(int exp, string tag);
      logic [N-1:0] eg;
      eg = (exp < 0) ? '0 : (N'(1) << exp);
      n_chk++;
      if (gnt_o !== eg || gnt_vld_o !== (exp >= 0) ||
          (exp >= 0 && int'(gnt_idx_o) != exp)) begin
         n_bad++;
         $display("FAIL %s: gnt=%b vld=%b idx=%0d, expected gnt=%b idx=%0d",
                  tag, gnt_o, gnt_vld_o, gnt_idx_o, eg, exp);
      end
   endfunction

   // driver: inputs for one cycle and the grant expected after its edge
   task automatic step(input logic [N-1:0] rq, input logic [N-1:0] bs,
                       input int exp, input string tag);
      @(negedge clk);
      req_i       = rq;
      burst_i     = bs;
      park_mode_i = s_mode;
      park_idx_i  = s_idx;
      slot_lim_i  = s_lim;
      q.push_back('{exp, tag});
   endtask

   // monitor: compare just after each edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         judge(e.exp, e.tag);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      judge(-1, "R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;

      // policy none, limit 0
      step(6'b000000, 6'b000000, -1, "R4 idle none");
      step(6'b000100, 6'b000000,  2, "R2 grant next edge");
      step(6'b000100, 6'b000100,  2, "R2 owner keeps");
      step(6'b000101, 6'b000100,  2, "R9 burst holds");
      for (int i = 0; i < 4; i++)
         step(6'b000101, 6'b000000, 2, "R10 zero limit no break");
      step(6'b000001, 6'b000000,  0, "R3 owner drops");
      step(6'b000000, 6'b000000, -1, "R4 idle none");
      step(6'b111111, 6'b000000,  1, "R3 rr from 1");
      step(6'b111101, 6'b000000,  2, "R3 rr to 2");
      step(6'b111011, 6'b000000,  3, "R3 rr to 3");
      step(6'b000011, 6'b000000,  0, "R3 rr wraps to 0");
      step(6'b000010, 6'b000000,  1, "R3 rr to 1");
      step(6'b000000, 6'b000000, -1, "R4 idle none");

      // slot limit 2
      s_lim = 8'd2;
      step(6'b000000, 6'b000000, -1, "R11 load limit");
      step(6'b000000, 6'b000000, -1, "R4 idle none");
      step(6'b010000, 6'b000000,  4, "R8 take m4");
      s_lim = 8'd0; // changed mid-ownership: must be ignored
      step(6'b010010, 6'b010000,  4, "R8 count 1");
      step(6'b010010, 6'b010000,  4, "R8 count 2");
      step(6'b010010, 6'b010000,  4, "R9 at limit in burst");
      step(6'b010010, 6'b000000,  1, "R8 break to m1 R11");
      step(6'b000010, 6'b000000,  1, "R8 m1 count 1");
      step(6'b000010, 6'b000000,  1, "R8 m1 count 2");
      step(6'b000010, 6'b000000,  1, "R8 limit no rival");
      step(6'b100010, 6'b000000,  5, "R8 break to m5 R11");
      s_lim = 8'd2;
      step(6'b000000, 6'b000000, -1, "R4 idle none");

      // last-owner parking
      s_mode = 2'd1;
      step(6'b000000, 6'b000000, -1, "R11 mode loads");
      step(6'b000000, 6'b000000,  5, "R5 park last");
      step(6'b000000, 6'b000000,  5, "R5 park last");
      step(6'b100000, 6'b000000,  5, "R7 parked m5 no gap");
      step(6'b000100, 6'b000000,  2, "R3 m2 from ptr 0");
      step(6'b000000, 6'b000000,  2, "R5 park on m2");

      // fixed parking on 3
      s_mode = 2'd2;
      s_idx  = 3'd3;
      step(6'b000000, 6'b000000,  2, "R11 fixed loads");
      step(6'b000000, 6'b000000,  3, "R6 park fixed");
      step(6'b001000, 6'b000000,  3, "R7 parked m3 no gap");
      step(6'b001001, 6'b000000,  3, "R8 below limit keep");
      step(6'b000001, 6'b000000,  0, "R3 m0 from ptr 3");
      step(6'b000000, 6'b000000,  3, "R6 back to fixed");
      s_idx = 3'd7;
      step(6'b000000, 6'b000000,  3, "R11 idx loads");
      step(6'b000000, 6'b000000, -1, "R6 idx out of range");
      s_mode = 2'd3;
      step(6'b000000, 6'b000000, -1, "R4 code 3");

      step(6'b000000, 6'b000000, -1, "R4 idle none");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule